// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block feeds the fractional divider of a fractional-N PLL with a signed offset word, one per reference clock cycle, so that the synthesized clock moves along a triangular frequency profile. Two profiles are available. The center profile is symmetric about the nominal rate. The down profile starts at nominal, falls to the full depth below it and climbs back, and it never goes above nominal. The offset word is in units of 2^-24 of one depth step, where one depth step is 1/10,000 of the nominal frequency. A sigma-delta stage further down the path adds the word to the divider's fractional part.

Software programs a quarter-period length in reference cycles, a depth code, a spread code and a ceiling on the positive excursion, and then raises the enable. The block checks the parameter set. For a legal set it computes the per-cycle step with a serial divider and starts the ramp. For an illegal set it raises the error flag and keeps the offset at zero. While the block is enabled it takes new parameters only at the end of a full triangle period, so the ramp never jumps partway through.

Top module: `ssc_mod_gen`

## Requirements
- R1: The depth code is legal only when it lies in the range 10 to 310 and is a multiple of 10. If an illegal depth is sampled, err_o is 1 and offset_o is 0 one clock edge later, and active_o is 0.
- R2: Spread code 1 selects the center profile and spread code 3 selects the down profile. Codes 0 and 2 are rejected in the same way as in R1.
- R3: The quarter length is legal from 50 cycles, which gives a full period of at least 200 reference cycles, up to REF_HZ/(4*MIN_MOD_HZ) cycles, which is 195 with the default parameters. A value outside this range is rejected as in R1.
- R4: In center mode the set is rejected when 6*depth > 10*lim, that is, when a peak of 1.2 times half the depth would exceed the ceiling. In down mode lim_i has no effect.
- R5: Let u = depth*2^23 and Q = quarter length, and let t = 0 be the first cycle with active_o high. In center mode the offset starts at 0 and rises to +u after Q cycles. It returns to 0 at 2Q, reaches -u at 3Q and is back at 0 at 4Q, and the pattern repeats every 4Q cycles.
- R6: In down mode the offset starts at 0 and falls through -u at Q to -2u at 2Q. It then rises through -u at 3Q back to 0 at 4Q, and it is never positive.
- R7: Inside a segment, cycle j holds the segment's start value plus or minus j*floor(depth*2^24/(2Q)). The last cycle of each segment holds the exact turning-point value, which is a multiple of u.
- R8: One edge after en_i is sampled low, offset_o, active_o and err_o are all 0, whatever the block was doing before.
- R9: A change to the inputs during a period has no effect until that period ends. At the end of the period, changed inputs send the block through a reload: active_o goes low and the offset stays at 0. The new profile then starts at t = 0.
- R10: active_o rises with offset_o equal to 0. The offset at that point is the start of the first segment.
- R11: Once err_o is set it stays set while en_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Modulation enable; a rising edge samples the parameters |
| qlen_i | input | QLEN_W | Quarter-period length in reference cycles |
| depth_i | input | DEPTH_W | Depth code in 1/10,000 of nominal |
| spread_i | input | 2 | Spread code: 1 for center, 3 for down |
| lim_i | input | DEPTH_W | Ceiling on the positive excursion, in depth units |
| offset_o | output | DEPTH_W+FB+1 | Signed frequency offset, 2^-FB depth units |
| err_o | output | 1 | Parameter set rejected |
| active_o | output | 1 | Ramp running |

## Verification
A corrupted step or accumulator value appears on offset_o on the very next cycle as a departure from the expected triangle. A wrong segment counter shows up as a turning point at the wrong cycle, at the latest within one quarter period. A wrong quotient from the divider shows up as a slope error that grows with every cycle, and it becomes largest just before the exact snap at the end of the segment. A reload or fault state that fails to leave shows up on active_o or err_o within one cycle of the edge of en_i or the end of a period.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RAMP, ST_FAULT} ssc_state_e;
  localparam logic [1:0] SPREAD_CENTER = 2'd1;
  localparam logic [1:0] SPREAD_DOWN   = 2'd3;
endpackage

// File: rtl/ssc_cfg_chk.sv
module ssc_cfg_chk import ssc_pkg::*; #(
  parameter int DEPTH_W    = 9,
  parameter int QLEN_W     = 8,
  parameter int DEPTH_MIN  = 10,
  parameter int DEPTH_MAX  = 310,
  parameter int DEPTH_STEP = 10,
  parameter int QLEN_MIN   = 50,
  parameter int QLEN_MAX   = 195
) (
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic [1:0]         spread_i,
  input  logic [QLEN_W-1:0]  qlen_i,
  input  logic [DEPTH_W-1:0] lim_i,
  output logic               ok_o
);
  localparam int PW = DEPTH_W + 4;
  localparam logic [DEPTH_W-1:0] DMIN  = DEPTH_W'(DEPTH_MIN);
  localparam logic [DEPTH_W-1:0] DMAX  = DEPTH_W'(DEPTH_MAX);
  localparam logic [DEPTH_W-1:0] DSTEP = DEPTH_W'(DEPTH_STEP);
  localparam logic [QLEN_W-1:0]  QMIN  = QLEN_W'(QLEN_MIN);
  localparam logic [QLEN_W-1:0]  QMAX  = QLEN_W'(QLEN_MAX);

  logic depth_ok, spread_ok, qlen_ok, peak_ok;
  logic [PW-1:0] peak6, lim10;

  assign depth_ok  = (depth_i >= DMIN) && (depth_i <= DMAX) && ((depth_i % DSTEP) == '0);
  assign spread_ok = (spread_i == SPREAD_CENTER) || (spread_i == SPREAD_DOWN);
  assign qlen_ok   = (qlen_i >= QMIN) && (qlen_i <= QMAX);
  // center peak reaches 1.2 * depth/2 -> compare 6*depth against 10*lim
  assign peak6     = PW'(depth_i) * PW'(6);
  assign lim10     = PW'(lim_i) * PW'(10);
  assign peak_ok   = (spread_i != SPREAD_CENTER) || (peak6 <= lim10);
  assign ok_o      = depth_ok && spread_ok && qlen_ok && peak_ok;
endmodule

// File: rtl/ssc_step_div.sv
module ssc_step_div #(
  parameter int NW = 33,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [NW-1:0] quo_o
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] quo_q;
  logic [DW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [DW:0]   rem_sh, rem_sub, rem_nx;
  logic          ge;
  logic          unused_rem_msb;

  assign rem_sh  = {rem_q, quo_q[NW-1]};
  assign ge      = rem_sh >= {1'b0, den_q};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign rem_nx  = ge ? rem_sub : rem_sh;
  assign unused_rem_msb = rem_nx[DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        quo_q <= num_i;
        rem_q <= '0;
        den_q <= den_i;
        cnt_q <= CW'(NW);
      end else if (cnt_q != '0) begin
        quo_q  <= {quo_q[NW-2:0], ge};
        rem_q  <= rem_nx[DW-1:0];
        cnt_q  <= cnt_q - CW'(1);
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/ssc_tri_acc.sv
module ssc_tri_acc #(
  parameter int FB      = 24,
  parameter int DEPTH_W = 9,
  parameter int QLEN_W  = 8,
  parameter int NW      = DEPTH_W + FB,
  parameter int OW      = DEPTH_W + FB + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 run_i,
  input  logic                 down_i,
  input  logic [DEPTH_W-1:0]   depth_i,
  input  logic [QLEN_W-1:0]    qlen_i,
  input  logic [NW-1:0]        step_i,
  output logic signed [OW-1:0] acc_o,
  output logic                 wrap_o
);
  logic [1:0]          seg_q;
  logic [QLEN_W-1:0]   cnt_q;
  logic signed [OW-1:0] acc_q, acc_nx, unit, stp, seg_end;
  logic                up, last;

  assign unit = $signed({{(OW-DEPTH_W){1'b0}}, depth_i}) <<< (FB-1);
  assign stp  = $signed({1'b0, step_i});
  assign last = (cnt_q == qlen_i - QLEN_W'(1));

  // segment direction and exact turning point
  always_comb begin
    case ({down_i, seg_q})
      3'b000:  begin up = 1'b1; seg_end = unit;          end
      3'b001:  begin up = 1'b0; seg_end = '0;            end
      3'b010:  begin up = 1'b0; seg_end = -unit;         end
      3'b011:  begin up = 1'b1; seg_end = '0;            end
      3'b100:  begin up = 1'b0; seg_end = -unit;         end
      3'b101:  begin up = 1'b0; seg_end = -(unit <<< 1); end
      3'b110:  begin up = 1'b1; seg_end = -unit;         end
      default: begin up = 1'b1; seg_end = '0;            end
    endcase
  end

  assign acc_nx = last ? seg_end : (up ? acc_q + stp : acc_q - stp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      seg_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      seg_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      acc_q <= acc_nx;
      if (last) begin
        cnt_q <= '0;
        seg_q <= seg_q + 2'd1;
      end else begin
        cnt_q <= cnt_q + QLEN_W'(1);
      end
    end
  end

  assign acc_o  = acc_q;
  assign wrap_o = run_i && last && (seg_q == 2'd3);
endmodule

// File: rtl/ssc_mod_gen.sv
module ssc_mod_gen import ssc_pkg::*; #(
  parameter int FB          = 24,
  parameter int DEPTH_W     = 9,
  parameter int QLEN_W      = 8,
  parameter int REF_HZ      = 25_000_000,
  parameter int MIN_MOD_HZ  = 32_000,
  parameter int QLEN_MIN    = 50
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [QLEN_W-1:0]            qlen_i,
  input  logic [DEPTH_W-1:0]           depth_i,
  input  logic [1:0]                   spread_i,
  input  logic [DEPTH_W-1:0]           lim_i,
  output logic signed [DEPTH_W+FB:0]   offset_o,
  output logic                         err_o,
  output logic                         active_o
);
  localparam int NW       = DEPTH_W + FB;
  localparam int OW       = NW + 1;
  localparam int DW       = QLEN_W + 1;
  localparam int QLEN_MAX = REF_HZ / (4 * MIN_MOD_HZ);

  ssc_state_e           state_q;
  logic [DEPTH_W-1:0]   depth_q, lim_q;
  logic [QLEN_W-1:0]    qlen_q;
  logic [1:0]           spread_q;
  logic                 down_q;
  logic                 cfg_ok, changed, wrap, sample, run;
  logic                 div_done;
  logic [NW-1:0]        div_quo;
  logic signed [OW-1:0] acc;

  ssc_cfg_chk #(
    .DEPTH_W(DEPTH_W), .QLEN_W(QLEN_W), .DEPTH_MIN(10), .DEPTH_MAX(310),
    .DEPTH_STEP(10), .QLEN_MIN(QLEN_MIN), .QLEN_MAX(QLEN_MAX)
  ) u_chk_cfg (
    .depth_i(depth_i), .spread_i(spread_i), .qlen_i(qlen_i), .lim_i(lim_i), .ok_o(cfg_ok)
  );

  assign changed = (depth_i != depth_q) || (qlen_i != qlen_q) ||
                   (spread_i != spread_q) || (lim_i != lim_q);
  assign sample  = en_i && ((state_q == ST_IDLE) ||
                            ((state_q == ST_RAMP) && wrap && changed));
  assign run     = en_i && (state_q == ST_RAMP);
  assign down_q  = (spread_q == SPREAD_DOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      depth_q  <= '0;
      lim_q    <= '0;
      qlen_q   <= '0;
      spread_q <= '0;
    end else begin
      if (sample) begin
        depth_q  <= depth_i;
        lim_q    <= lim_i;
        qlen_q   <= qlen_i;
        spread_q <= spread_i;
      end
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE:  state_q <= cfg_ok ? ST_LOAD : ST_FAULT;
          ST_LOAD:  if (div_done) state_q <= ST_RAMP;
          ST_RAMP:  if (wrap && changed) state_q <= cfg_ok ? ST_LOAD : ST_FAULT;
          default:  state_q <= ST_FAULT;
        endcase
      end
    end
  end

  ssc_step_div #(.NW(NW), .DW(DW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(sample && cfg_ok),
    .num_i({depth_i, {FB{1'b0}}}),
    .den_i({qlen_i, 1'b0}),
    .done_o(div_done), .quo_o(div_quo)
  );

  ssc_tri_acc #(.FB(FB), .DEPTH_W(DEPTH_W), .QLEN_W(QLEN_W), .NW(NW), .OW(OW)) u_tri (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(!run), .run_i(run), .down_i(down_q),
    .depth_i(depth_q), .qlen_i(qlen_q), .step_i(div_quo),
    .acc_o(acc), .wrap_o(wrap)
  );

  assign offset_o = acc;
  assign err_o    = (state_q == ST_FAULT);
  assign active_o = (state_q == ST_RAMP);
endmodule

// File: rtl/ssc_mod_gen_chk.sv
module ssc_mod_gen_chk #(
  parameter int OW      = 34,
  parameter int NW      = 33,
  parameter int FB      = 24,
  parameter int DEPTH_W = 9,
  parameter int QLEN_W  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic signed [OW-1:0] offset_o,
  input logic                 err_o,
  input logic                 active_o,
  input logic                 down_q,
  input logic [DEPTH_W-1:0]   depth_q,
  input logic [QLEN_W-1:0]    qlen_q,
  input logic [NW-1:0]        div_quo
);
  logic signed [OW-1:0] unit, prev_q;
  logic                 act_prev_q;
  logic signed [OW:0]   delta, mag;
  logic [OW:0]          bound;

  assign unit  = $signed({{(OW-DEPTH_W){1'b0}}, depth_q}) <<< (FB-1);
  assign delta = {offset_o[OW-1], offset_o} - {prev_q[OW-1], prev_q};
  assign mag   = delta[OW] ? -delta : delta;
  assign bound = {2'b00, div_quo} + {{(OW+1-QLEN_W){1'b0}}, qlen_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      act_prev_q <= 1'b0;
    end else begin
      prev_q     <= offset_o;
      act_prev_q <= active_o;
    end
  end

  AST_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_o == '0) && !active_o && !err_o); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (offset_o == '0) && !active_o); // R1
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && en_i) |=> err_o); // R11
  AST_DOWN_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && down_q) |-> (offset_o[OW-1] || (offset_o == '0))); // R6
  AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !down_q) |-> ((offset_o <= unit) && (offset_o >= -unit))); // R5
  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> (offset_o == '0)); // R10
  AST_STEP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && act_prev_q) |-> ($unsigned(mag) <= bound)); // R7
endmodule

bind ssc_mod_gen ssc_mod_gen_chk #(
  .OW(OW), .NW(NW), .FB(FB), .DEPTH_W(DEPTH_W), .QLEN_W(QLEN_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .offset_o(offset_o),
  .err_o(err_o), .active_o(active_o), .down_q(down_q), .depth_q(depth_q),
  .qlen_q(qlen_q), .div_quo(div_quo)
);

// File: tb/ssc_mod_gen_tb.sv
module ssc_mod_gen_tb;
  localparam int FB = 24, DEPTH_W = 9, QLEN_W = 8;
  localparam int QMAX = 25_000_000 / (4 * 32_000);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [QLEN_W-1:0]  qlen = '0;
  logic [DEPTH_W-1:0] depth = '0, lim = '0;
  logic [1:0]         spread = '0;
  logic signed [DEPTH_W+FB:0] offset;
  logic err, active;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssc_mod_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .qlen_i(qlen), .depth_i(depth),
    .spread_i(spread), .lim_i(lim), .offset_o(offset), .err_o(err), .active_o(active)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal(int d, int s, int q, int l);
    bit ok = (d >= 10) && (d <= 310) && (d % 10 == 0);
    ok = ok && (s == 1 || s == 3) && (q >= 50) && (q <= QMAX);
    if (s == 1 && 6 * d > 10 * l) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint ep_of(int s, int seg, longint u);
    if (s == 1) return (seg == 0) ? u : (seg == 2) ? -u : 0;
    return (seg == 0 || seg == 2) ? -u : (seg == 1) ? -2 * u : 0;
  endfunction

  function automatic longint dir_of(int s, int seg);
    if (s == 1) return (seg == 0 || seg == 3) ? 1 : -1;
    return (seg >= 2) ? 1 : -1;
  endfunction

  function automatic longint exp_off(int d, int s, int q, int t);
    longint u  = longint'(d) <<< 23;
    longint st = (longint'(d) <<< 24) / longint'(2 * q);
    int tt = t % (4 * q);
    int seg, j;
    longint base;
    if (tt == 0) return 0;
    seg = (tt - 1) / q;
    j   = (tt - 1) % q + 1;
    base = (seg == 0) ? 0 : ep_of(s, seg - 1, u);
    if (j == q) return ep_of(s, seg, u);
    return base + dir_of(s, seg) * longint'(j) * st;
  endfunction

  task automatic apply(int d, int s, int q, int l);
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    depth = DEPTH_W'(d); spread = 2'(s); qlen = QLEN_W'(q); lim = DEPTH_W'(l);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_active(string tag);
    int k = 0;
    while (!active && k < 200) begin @(negedge clk); k++; end
    chk(active, tag, longint'(active), 1);
  endtask

  task automatic check_period(int d, int s, int q, int nper, int cut);
    string tag = (s == 1) ? "R5 R7" : "R6 R7";
    for (int t = 0; t <= nper * 4 * q; t++) begin
      if (t == cut) begin en = 1'b0; @(negedge clk);
        chk(offset == 0 && !active && !err, "R8 disable", longint'(offset), 0);
        return;
      end
      chk(longint'(offset) == exp_off(d, s, q, t), (t == 0) ? "R10 start" : tag,
          longint'(offset), exp_off(d, s, q, t));
      if (t < nper * 4 * q) @(negedge clk);
    end
  endtask

  task automatic run_case(int d, int s, int q, int l, string etag);
    apply(d, s, q, l);
    if (!legal(d, s, q, l)) begin
      chk(err && offset == 0 && !active, etag, longint'(err), 1);
      repeat (3) @(negedge clk);
      chk(err, "R11 hold", longint'(err), 1);
      en = 1'b0; @(negedge clk);
      chk(!err && offset == 0, "R8 clear", longint'(err), 0);
    end else begin
      chk(!err, etag, longint'(err), 0);
      wait_active(etag);
      check_period(d, s, q, 1, -1);
      en = 1'b0; @(negedge clk);
      chk(offset == 0 && !active, "R8 off", longint'(offset), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(offset == 0 && !err && !active, "R8 reset", longint'(offset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 depth legality
    run_case(5, 1, 60, 200, "R1 low");
    run_case(315, 3, 60, 0, "R1 high");
    run_case(55, 3, 60, 0, "R1 step");
    run_case(10, 1, 50, 10, "R1 min");
    run_case(310, 3, 60, 0, "R1 max");
    // R2 spread codes
    run_case(100, 0, 60, 200, "R2 code0");
    run_case(100, 2, 60, 200, "R2 code2");
    // R3 quarter length
    run_case(50, 3, 49, 0, "R3 short");
    run_case(50, 3, QMAX, 0, "R3 longest");
    run_case(50, 3, QMAX + 1, 0, "R3 long");
    // R4 center ceiling
    run_case(100, 1, 60, 59, "R4 over");
    run_case(100, 1, 60, 60, "R4 edge");
    run_case(300, 3, 70, 0, "R4 down ignores lim");
    // R6 longer down profile over two periods
    apply(250, 3, 55, 0);
    wait_active("R6 two periods");
    check_period(250, 3, 55, 2, -1);
    // R8 disable mid ramp
    apply(120, 1, 64, 100);
    wait_active("R8 mid");
    check_period(120, 1, 64, 1, 37);
    // R9 change mid-period, reload at period end
    apply(100, 1, 50, 200);
    wait_active("R9 first");
    for (int t = 0; t <= 200; t++) begin
      if (t == 7) begin depth = 9'd200; spread = 2'd3; qlen = 8'd60; end
      chk(longint'(offset) == exp_off(100, 1, 50, t), "R9 old profile kept",
          longint'(offset), exp_off(100, 1, 50, t));
      if (t < 200) @(negedge clk);
    end
    @(negedge clk);
    chk(!active && offset == 0, "R9 reload", longint'(active), 0);
    wait_active("R9 second");
    check_period(200, 3, 60, 1, -1);
    en = 1'b0; @(negedge clk);
    // random mix
    for (int i = 0; i < 14; i++) begin
      int d, s, q, l;
      d = ($urandom_range(9, 0) < 7) ? 10 * $urandom_range(31, 1) : $urandom_range(400, 0);
      case ($urandom_range(4, 0))
        0, 1: s = 1;
        2, 3: s = 3;
        default: s = $urandom_range(3, 0);
      endcase
      q = $urandom_range(200, 45);
      l = $urandom_range(250, 0);
      run_case(d, s, q, l, "R1 R2 R3 R4 random");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule